// File: doc/BRIEF.md
# 6-and-2 Sector Data Encoder

This block converts a 256-byte sector held in an external buffer into the nibble stream of one data field of a 16-sector floppy track. A `start` pulse begins a field. The block then reads the whole buffer once through a byte-read port. It gathers the low two bits of every byte into 86 auxiliary 6-bit values, taking one value from each of three interleaved thirds of the buffer, and holds them in local registers.

It then switches the drive into write mode and emits 355 nibbles, one per fixed time slot. The stream is a sync run and a three-nibble prologue, followed by 342 data codes and a checksum code, and ends with a three-nibble epilogue and a turn-off nibble. Each data code is a table translation of the XOR of the current 6-bit value with the previous one, so the chain forms a running checksum. The 64-entry translation table is not stored. It is derived in logic from the rule that defines a legal disk code. If the write-protect input is high when `start` arrives, the block emits nothing and reports an error at once.

A downstream serialiser takes `nib_out` when `nib_vld` pulses. `SLOT_CLKS` sets the slot period in clock cycles: 8000 cycles at 250 MHz gives the 32 µs nibble slot.

Top module: `sector_nib_encoder`

## Requirements
- R1: After reset, `nib_vld`, `wr_mode`, `done` and `wp_err` are all 0.
- R2: A field opens with five 0xFF sync nibbles and then 0xD5, 0xAA, 0xAD (stream positions 0 to 7).
- R3: Auxiliary value i (0..85) holds the low bits of byte i in bits 1:0, of byte i+86 in bits 3:2 and of byte i+172 in bits 5:4. Byte bit 0 goes to the higher bit of its pair. For i = 84 and 85 the 5:4 pair is zero.
- R4: The data values are the 86 auxiliary values from index 85 down to 0, followed by bits 7:2 of bytes 0 to 255 in ascending order.
- R5: Data nibble k (stream position 8+k) is T[v(k) XOR v(k-1)], with v(-1) = 0. Position 350 carries the checksum T[v(341)].
- R6: T[n] is the n-th code, counted in ascending order, that lies in 0x96..0xFF, has at most one pair of adjacent 0 bits, and has at least one pair of adjacent 1 bits within bits 6:0. There are 64 such codes, T[0] = 0x96 and T[63] = 0xFF.
- R7: Positions 351 to 354 are 0xDE, 0xAA, 0xEB, 0xFF.
- R8: Consecutive `nib_vld` pulses of one field are exactly `SLOT_CLKS` cycles apart.
- R9: If `wr_protect` is high when an accepted `start` is seen, the next cycle carries a single `done` pulse together with `wp_err`, and no nibble is emitted and `wr_mode` is not raised.
- R10: `wr_mode` is high only while a field is being emitted. It covers every `nib_vld` and is low when `done` pulses.
- R11: A `start` pulse (with any `wr_protect` value) that arrives while a field is in progress is ignored.
- R12: A field has exactly 355 nibbles. `done` pulses once, `SLOT_CLKS` cycles after the last `nib_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one field (accepted when idle) |
| wr_protect | input | 1 | Medium is write protected |
| rd_addr | output | 8 | Buffer byte address |
| rd_data | input | 8 | Buffer byte at `rd_addr`, same cycle |
| nib_out | output | 8 | Current disk nibble |
| nib_vld | output | 1 | One-cycle strobe: `nib_out` starts a slot |
| wr_mode | output | 1 | Drive is in write mode |
| done | output | 1 | One-cycle pulse: field finished or aborted |
| wp_err | output | 1 | With `done`: aborted on write protect |

## Verification
The field is driven with an all-zero buffer, where every data nibble must be 0x96, and with an all-ones buffer, which exposes the missing third group at auxiliary indices 84 and 85. A sparse buffer that sets single low bits in bytes 1 and 172 separates a swapped bit pair, a wrong group offset and a wrong emission order. Random buffers, compared against a bench model of the aux packing, XOR chain and table rule, catch errors in the chaining and the checksum. Other runs cover a write-protect abort, a start pulse during emission, and a field that follows an abort.

// File: rtl/nib_enc_pkg.sv
package nib_enc_pkg;

  localparam int SEC_BYTES = 256;
  localparam int AUX_N     = 86;
  localparam int GRP2_OFS  = 86;
  localparam int GRP3_OFS  = 172;
  localparam int N_SYNC    = 5;
  localparam int P_DATA    = N_SYNC + 3;
  localparam int N_DATA    = AUX_N + SEC_BYTES;
  localparam int P_BYTES   = P_DATA + AUX_N;
  localparam int P_CSUM    = P_DATA + N_DATA;
  localparam int N_NIBS    = P_CSUM + 1 + 4;

  typedef enum logic [1:0] {ST_IDLE, ST_GATHER, ST_EMIT} enc_state_t;

  // Legal disk code: top bit set, no more than one adjacent-zero pair,
  // some adjacent-one pair below the top bit, and not below 0x96.
  function automatic logic code_ok(input logic [7:0] c);
    return c[7] && (c >= 8'h96)
        && ($countones(~c[7:1] & ~c[6:0]) <= 1)
        && ((c[6:1] & c[5:0]) != 6'd0);
  endfunction

  // n-th legal code in ascending order
  function automatic logic [7:0] xlate(input logic [5:0] v);
    logic [6:0] n;
    logic [7:0] r;
    n = 7'd0;
    r = 8'hFF;
    for (int c = 128; c < 256; c++) begin
      if (code_ok(8'(c))) begin
        if (n == {1'b0, v}) r = 8'(c);
        n = n + 7'd1;
      end
    end
    return r;
  endfunction

  function automatic logic [1:0] swap2(input logic [1:0] x);
    return {x[0], x[1]};
  endfunction

endpackage

// File: rtl/aux_gather.sv
module aux_gather
  import nib_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] byte_in,
  input  logic [6:0] rd_idx,
  output logic [5:0] rd_val
);

  logic [5:0] aux_w [AUX_N];

  for (genvar i = 0; i < AUX_N; i++) begin : g_ent
    logic [5:0] ent;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent <= 6'd0;
      end else if (clr) begin
        ent <= 6'd0;
      end else if (wr_en) begin
        if ({1'b0, addr} == 9'(i))            ent[1:0] <= swap2(byte_in[1:0]);
        if ({1'b0, addr} == 9'(i + GRP2_OFS)) ent[3:2] <= swap2(byte_in[1:0]);
        if ({1'b0, addr} == 9'(i + GRP3_OFS)) ent[5:4] <= swap2(byte_in[1:0]);
      end
    end
    assign aux_w[i] = ent;
  end

  assign rd_val = (rd_idx < 7'(AUX_N)) ? aux_w[rd_idx] : 6'd0;

endmodule

// File: rtl/slot_timer.sv
module slot_timer #(
  parameter int SLOT_CLKS = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic load,
  output logic tick
);

  localparam int W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam logic [W-1:0] LAST = W'(SLOT_CLKS - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= LAST;
    else if (run)            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

endmodule

// File: rtl/sector_nib_encoder.sv
module sector_nib_encoder
  import nib_enc_pkg::*;
#(
  parameter int SLOT_CLKS = 8000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       wr_protect,
  output logic [7:0] rd_addr,
  input  logic [7:0] rd_data,
  output logic [7:0] nib_out,
  output logic       nib_vld,
  output logic       wr_mode,
  output logic       done,
  output logic       wp_err
);

  enc_state_t state;
  logic [7:0] gcnt;
  logic [8:0] pos;
  logic [5:0] prev;

  // named internal events
  wire start_ok    = (state == ST_IDLE) && start && !wr_protect;
  wire start_wp    = (state == ST_IDLE) && start && wr_protect;
  wire gather_last = (state == ST_GATHER) && (gcnt == 8'hFF);
  wire in_aux      = (pos >= 9'(P_DATA))  && (pos < 9'(P_BYTES));
  wire in_bytes    = (pos >= 9'(P_BYTES)) && (pos < 9'(P_CSUM));
  wire is_csum     = (pos == 9'(P_CSUM));
  wire slot_tick;

  logic [6:0] aux_idx;
  logic [5:0] aux_val;
  logic [5:0] cur_val;
  logic [7:0] code;
  logic [7:0] nib_next;

  slot_timer #(.SLOT_CLKS(SLOT_CLKS)) u_slot (
    .clk(clk), .rst_n(rst_n), .run(state == ST_EMIT),
    .load(gather_last), .tick(slot_tick)
  );

  aux_gather u_aux (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .wr_en(state == ST_GATHER),
    .addr(gcnt), .byte_in(rd_data), .rd_idx(aux_idx), .rd_val(aux_val)
  );

  assign aux_idx = 7'(9'(P_BYTES - 1) - pos);
  assign rd_addr = (state == ST_GATHER) ? gcnt : 8'(pos - 9'(P_BYTES));
  assign cur_val = in_aux ? aux_val : rd_data[7:2];
  assign code    = xlate(is_csum ? prev : (cur_val ^ prev));

  always_comb begin
    unique case (pos)
      9'd5:   nib_next = 8'hD5;
      9'd6:   nib_next = 8'hAA;
      9'd7:   nib_next = 8'hAD;
      9'd351: nib_next = 8'hDE;
      9'd352: nib_next = 8'hAA;
      9'd353: nib_next = 8'hEB;
      default: nib_next = (in_aux || in_bytes || is_csum) ? code : 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      gcnt    <= 8'd0;
      pos     <= 9'd0;
      prev    <= 6'd0;
      nib_out <= 8'd0;
      nib_vld <= 1'b0;
      wr_mode <= 1'b0;
      done    <= 1'b0;
      wp_err  <= 1'b0;
    end else begin
      nib_vld <= 1'b0;
      done    <= 1'b0;
      wp_err  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_wp) begin
            done   <= 1'b1;
            wp_err <= 1'b1;
          end else if (start_ok) begin
            state <= ST_GATHER;
            gcnt  <= 8'd0;
            pos   <= 9'd0;
            prev  <= 6'd0;
          end
        end
        ST_GATHER: begin
          gcnt <= gcnt + 8'd1;
          if (gather_last) begin
            state   <= ST_EMIT;
            wr_mode <= 1'b1;
          end
        end
        ST_EMIT: begin
          if (slot_tick) begin
            if (pos == 9'(N_NIBS)) begin
              done    <= 1'b1;
              wr_mode <= 1'b0;
              state   <= ST_IDLE;
            end else begin
              nib_out <= nib_next;
              nib_vld <= 1'b1;
              pos     <= pos + 9'd1;
              if (in_aux || in_bytes) prev <= cur_val;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  int gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              gap <= 0;
    else if (nib_vld)        gap <= 1;
    else if (gap < SLOT_CLKS + 2) gap <= gap + 1;
  end

  p_slot_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_vld && pos != 9'd1) |-> (gap == SLOT_CLKS));

  p_vld_in_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    nib_vld |-> wr_mode);

  p_done_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_mode);

  p_wp_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_wp |=> (done && wp_err && !nib_vld && !wr_mode));

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wp_err |-> done);

  p_code_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_vld && pos > 9'(P_DATA) && pos <= 9'(P_CSUM + 1)) |-> code_ok(nib_out));

endmodule

// File: tb/sim_sector_nib_encoder.sv
`timescale 1ns/1ps
module sim_sector_nib_encoder;

  localparam int SLOT = 12;
  localparam int NN   = 355;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic wr_protect = 1'b0;
  logic [7:0] rd_addr, rd_data, nib_out;
  logic nib_vld, wr_mode, done, wp_err;

  logic [7:0] mem [256];
  assign rd_data = mem[rd_addr];

  always #2 clk = ~clk;

  sector_nib_encoder #(.SLOT_CLKS(SLOT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_protect(wr_protect),
    .rd_addr(rd_addr), .rd_data(rd_data), .nib_out(nib_out),
    .nib_vld(nib_vld), .wr_mode(wr_mode), .done(done), .wp_err(wp_err)
  );

  int checks = 0, errs = 0;
  int cyc = 0, ncap = 0, ndone = 0, nwp = 0, done_cyc = 0;
  bit wr_seen = 0;
  logic [7:0] cap [512];
  int capcyc [512];
  logic [7:0] tbl [64];
  logic [7:0] expn [NN];

  always @(negedge clk) begin
    cyc++;
    if (nib_vld && ncap < 512) begin
      cap[ncap] = nib_out; capcyc[ncap] = cyc; ncap++;
    end
    if (done) begin ndone++; done_cyc = cyc; end
    if (wp_err) nwp++;
    if (wr_mode) wr_seen = 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // bench view of the code rule: count bit pairs one at a time
  function automatic bit legal(input int c);
    int z = 0, o = 0;
    for (int k = 0; k < 7; k++) if (!c[k] && !c[k+1]) z++;
    for (int k = 0; k < 6; k++) if (c[k] && c[k+1]) o++;
    return (c >= 150) && (c <= 255) && (z <= 1) && (o > 0);
  endfunction

  function automatic int lowpair(input int a);
    if (a > 255) return 0;
    return ((mem[a] & 1) << 1) | ((mem[a] >> 1) & 1);
  endfunction

  task automatic build_expected();
    int v [342];
    int p = 0;
    for (int j = 0; j < 86; j++) begin
      int i = 85 - j;
      v[j] = lowpair(i) + 4 * lowpair(i + 86) + 16 * lowpair(i + 172);
    end
    for (int k = 0; k < 256; k++) v[86 + k] = mem[k] / 4;
    for (int k = 0; k < 5; k++) expn[k] = 8'hFF;
    expn[5] = 8'hD5; expn[6] = 8'hAA; expn[7] = 8'hAD;
    for (int k = 0; k < 342; k++) begin
      expn[8 + k] = tbl[v[k] ^ p];
      p = v[k];
    end
    expn[350] = tbl[p];
    expn[351] = 8'hDE; expn[352] = 8'hAA; expn[353] = 8'hEB; expn[354] = 8'hFF;
  endtask

  task automatic cmp_range(input int lo, input int hi, input string req,
                           input string what);
    int bad = -1;
    for (int k = lo; k < hi; k++)
      if (bad < 0 && (k >= ncap || cap[k] !== expn[k])) bad = k;
    if (bad < 0) check(1'b1, req, what, 0, 0);
    else check(1'b0, req, $sformatf("%s at position %0d", what, bad),
               (bad < ncap) ? int'(cap[bad]) : -1, int'(expn[bad]));
  endtask

  task automatic run_field(input string name, input bit poke);
    int w = 0;
    bit poked = 0;
    bit gap_ok = 1;
    build_expected();
    @(posedge clk);
    ncap = 0; ndone = 0; nwp = 0; wr_seen = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (ndone == 0 && w < 20000) begin
      @(negedge clk);
      w++;
      if (poke && !poked && ncap == 100) begin
        poked = 1;
        wr_protect = 1'b1; start = 1'b1;
        @(negedge clk);
        wr_protect = 1'b0; start = 1'b0;
      end
    end
    repeat (3) @(negedge clk);
    check(ncap == NN, "R12", {name, " nibble count"}, ncap, NN);
    cmp_range(0, 8, "R2", {name, " sync and prologue"});
    cmp_range(8, 94, "R3 R4 R5", {name, " aux codes"});
    cmp_range(94, 350, "R4 R5", {name, " byte codes"});
    cmp_range(350, 351, "R5", {name, " checksum"});
    cmp_range(351, 355, "R7", {name, " epilogue"});
    for (int k = 1; k < ncap; k++)
      if (capcyc[k] - capcyc[k-1] != SLOT) gap_ok = 0;
    check(gap_ok, "R8", {name, " slot spacing"}, gap_ok, 1);
    check(ndone == 1 && ncap > 0 && done_cyc - capcyc[ncap-1] == SLOT, "R12",
          {name, " done timing"}, ndone, 1);
    check(nwp == 0, poke ? "R11" : "R9", {name, " no error"}, nwp, 0);
    check(wr_seen && !wr_mode, "R10", {name, " write mode window"}, wr_mode, 0);
  endtask

  initial begin
    #(4 * 190000);
    errs++;
    $display("FAIL watchdog: run did not end, actual running expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    int cnt = 0;
    void'($urandom(32'd20240611));
    for (int c = 0; c < 256; c++)
      if (legal(c)) begin if (cnt < 64) tbl[cnt] = 8'(c); cnt++; end
    check(cnt == 64, "R6", "legal code count", cnt, 64);
    check(tbl[0] == 8'h96 && tbl[63] == 8'hFF, "R6", "table ends", tbl[0], 8'h96);
    for (int k = 0; k < 256; k++) mem[k] = 8'h00;

    repeat (3) @(negedge clk);
    check(!nib_vld && !wr_mode && !done && !wp_err, "R1", "outputs in reset",
          {nib_vld, wr_mode, done, wp_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!nib_vld && !wr_mode && !done && !wp_err, "R1", "outputs after reset",
          {nib_vld, wr_mode, done, wp_err}, 0);

    run_field("zeros", 0);
    check(cap[200] == 8'h96 && cap[350] == 8'h96, "R6", "zero data code",
          cap[200], 8'h96);

    for (int k = 0; k < 256; k++) mem[k] = 8'hFF;
    run_field("ones", 0);

    for (int k = 0; k < 256; k++) mem[k] = 8'h00;
    mem[1] = 8'h02; mem[172] = 8'h01;
    run_field("sparse", 0);
    check(cap[92] == tbl[1], "R3", "aux 1 bit swap", cap[92], tbl[1]);
    check(cap[93] == tbl[33], "R3", "aux 0 third group", cap[93], tbl[33]);
    check(cap[94] == tbl[32], "R5", "chain into bytes", cap[94], tbl[32]);

    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 256; k++) mem[k] = 8'($urandom);
      run_field($sformatf("random%0d", r), r == 1);
    end

    // write-protect abort
    @(posedge clk);
    ncap = 0; ndone = 0; nwp = 0; wr_seen = 0;
    @(negedge clk) begin wr_protect = 1'b1; start = 1'b1; end
    @(negedge clk) begin start = 1'b0; end
    check(done && wp_err, "R9", "abort pulse next cycle", {done, wp_err}, 3);
    repeat (SLOT * 3) @(negedge clk);
    wr_protect = 1'b0;
    check(ndone == 1 && nwp == 1, "R9", "single abort pulse", ndone, 1);
    check(ncap == 0 && !wr_seen, "R9", "nothing emitted on abort", ncap, 0);

    for (int k = 0; k < 256; k++) mem[k] = 8'($urandom);
    run_field("after_abort", 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

endmodule